// File: doc/BRIEF.md
# Radio Coexistence Arbitration Controller

This block sits between a short-range radio's link controller and a collocated wireless LAN chip. The two chips share four general-purpose pins. A configuration register picks one of five coexistence schemes, and the block maps the request, confirm, status and not-allowed functions of that scheme onto the pins. It also produces one registered `radio_allowed` output, which gates the local transmitter and receiver.

The local link controller raises `act_req` when it wants the medium and `act_prio` when that traffic is high priority. In the two-wire scheme, `host_master` tells the block which radio is master. Pin inputs are asynchronous to the block clock and pass through a two-flop synchroniser before they reach the gating decision. Pin outputs and output enables are registered, so the pads see glitch-free values.

Top module: `coex_arbiter`

## Requirements
- R1: During reset and after it, `pin_out`, `pin_oe` and `radio_allowed` are all 0. The scheme register resets to code 0 (traffic arbitration), so enabling coexistence with no request gives `pin_oe`=4'b0110 two cycles later.
- R2: A write (`cfg_we`=1) with `cfg_mode` 0..4 selects a scheme: 0 traffic arbitration, 1 LAN master, 2 local master, 3 two-wire, 4 medium alternation. A write with code 5, 6 or 7 is ignored and the previous scheme stays in force.
- R3: With `coex_en`=0, all `pin_oe` and `pin_out` bits are 0 one cycle later, and `radio_allowed` equals `act_req` of the previous cycle.
- R4: Scheme 0 pin map (bit 0 is pin 1):
  - Bits 1 and 2 are driven and bits 0 and 3 are inputs, so `pin_oe`=4'b0110.
  - `pin_out[1]` is the request (`act_req`).
  - `pin_out[2]` is the priority status (`act_req & act_prio`).
  - Bits 0 and 3 of `pin_out` are 0.
- R5: In scheme 0, `radio_allowed` is 1 only when all of these hold: `act_req` is set, the synchronised confirm (`pin_in[0]`) is high, and the synchronised LAN high-priority line (`pin_in[3]`) is not high while `act_prio` is 0. When the synchronised confirm falls, `radio_allowed` falls on the next clock.
- R6: In scheme 1 no pin is driven. `radio_allowed` is `act_req` while the synchronised `pin_in[0]` (LAN not-allowed) is low, and 0 while it is high.
- R7: In scheme 2 only bit 1 is driven (`pin_oe`=4'b0010). `pin_out[1]` follows `act_req`, and `radio_allowed` follows `act_req` whatever the pin inputs are.
- R8: In scheme 3, `pin_oe`=4'b0010.
  - With `host_master`=1, the block behaves as scheme 2.
  - With `host_master`=0, `pin_out[1]` is 0 and the block gates as scheme 1.
- R9: In scheme 4 no pin is driven. `radio_allowed` is `act_req` only while the synchronised medium-free line `pin_in[0]` is high.
- R10: A change on `pin_in` has not reached `radio_allowed` two rising edges after it is applied, and has reached it after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coex_en | input | 1 | Enables the coexistence interface |
| cfg_we | input | 1 | Write strobe for the scheme register |
| cfg_mode | input | 3 | Scheme code to write |
| host_master | input | 1 | Two-wire scheme: 1 makes the local radio master |
| act_req | input | 1 | Local radio wants the medium |
| act_prio | input | 1 | Local request is high priority |
| pin_in | input | 4 | Values sampled from the four shared pins |
| pin_out | output | 4 | Drive values for the shared pins |
| pin_oe | output | 4 | Output enables for the shared pins |
| radio_allowed | output | 1 | Local transmitter/receiver may operate |

## Verification
The bench measures the synchroniser latency edge by edge. A block with one flop too few would raise `radio_allowed` a cycle early, and one that skipped the synchroniser would react at once. It writes an illegal scheme code and checks that the pin map stays unchanged; a register that accepted any code would float all pins or select a wrong map. It toggles `host_master` in the two-wire scheme and the LAN high-priority line against local priority in scheme 0, where a swapped decode would grant the medium to the losing side.

// File: rtl/coex_pkg.sv
package coex_pkg;

  localparam int unsigned COEX_PINS  = 4;
  localparam int unsigned MODE_W     = 3;

  // Pin roles; bit positions matter because the neighbour chip decodes them.
  localparam int unsigned PIN_GATE   = 0; // confirm / not-allowed / medium-free input
  localparam int unsigned PIN_REQ    = 1; // request or local-busy output
  localparam int unsigned PIN_STAT   = 2; // priority status output
  localparam int unsigned PIN_OPT    = 3; // peer high-priority input

  typedef enum logic [MODE_W-1:0] {
    MODE_ARB       = 3'd0,
    MODE_LAN_MST   = 3'd1,
    MODE_LOCAL_MST = 3'd2,
    MODE_TWO_WIRE  = 3'd3,
    MODE_ALTERNATE = 3'd4
  } coex_mode_e;

  function automatic logic mode_is_legal(input logic [MODE_W-1:0] code);
    return code <= 3'd4;
  endfunction

endpackage

// File: rtl/coex_sync.sv
module coex_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/coex_mode_reg.sv
module coex_mode_reg
  import coex_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_mode,
  output coex_mode_e        mode_q
);

  coex_mode_e mode_d;
  logic       load_en;

  always_comb begin
    load_en = cfg_we && mode_is_legal(cfg_mode);
    mode_d  = coex_mode_e'(cfg_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_ARB;
    else if (load_en) mode_q <= mode_d;
  end

endmodule

// File: rtl/coex_pin_map.sv
module coex_pin_map
  import coex_pkg::*;
(
  input  logic                 coex_en,
  input  coex_mode_e           mode,
  input  logic                 host_master,
  input  logic                 act_req,
  input  logic                 act_prio,
  input  logic                 gate_s,   // synchronised pin 1
  input  logic                 peer_hp_s,// synchronised pin 4
  output logic [COEX_PINS-1:0] out_d,
  output logic [COEX_PINS-1:0] oe_d,
  output logic                 allowed_d
);

  always_comb begin
    out_d     = '0;
    oe_d      = '0;
    allowed_d = act_req;
    if (coex_en) begin
      unique case (mode)
        MODE_ARB: begin
          oe_d[PIN_REQ]   = 1'b1;
          oe_d[PIN_STAT]  = 1'b1;
          out_d[PIN_REQ]  = act_req;
          out_d[PIN_STAT] = act_req & act_prio;
          allowed_d       = act_req & gate_s & ~(peer_hp_s & ~act_prio);
        end
        MODE_LAN_MST: begin
          allowed_d = act_req & ~gate_s;
        end
        MODE_LOCAL_MST: begin
          oe_d[PIN_REQ]  = 1'b1;
          out_d[PIN_REQ] = act_req;
          allowed_d      = act_req;
        end
        MODE_TWO_WIRE: begin
          oe_d[PIN_REQ] = 1'b1;
          if (host_master) begin
            out_d[PIN_REQ] = act_req;
            allowed_d      = act_req;
          end else begin
            allowed_d      = act_req & ~gate_s;
          end
        end
        MODE_ALTERNATE: begin
          allowed_d = act_req & gate_s;
        end
        default: begin
          allowed_d = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/coex_arbiter.sv
module coex_arbiter
  import coex_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 coex_en,
  input  logic                 cfg_we,
  input  logic [MODE_W-1:0]    cfg_mode,
  input  logic                 host_master,
  input  logic                 act_req,
  input  logic                 act_prio,
  input  logic [COEX_PINS-1:0] pin_in,
  output logic [COEX_PINS-1:0] pin_out,
  output logic [COEX_PINS-1:0] pin_oe,
  output logic                 radio_allowed
);

  localparam int unsigned SYNC_W = 2;

  coex_mode_e          mode_q;
  logic [SYNC_W-1:0]   sync_raw;
  logic [SYNC_W-1:0]   sync_q;
  logic [COEX_PINS-1:0] out_d, oe_d;
  logic                allowed_d;
  logic                unused_pins;

  assign sync_raw    = {pin_in[PIN_OPT], pin_in[PIN_GATE]};
  assign unused_pins = ^{pin_in[PIN_REQ], pin_in[PIN_STAT]};

  coex_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_mode (cfg_mode),
    .mode_q   (mode_q)
  );

  coex_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sync_raw),
    .sync_out (sync_q)
  );

  coex_pin_map u_map (
    .coex_en     (coex_en),
    .mode        (mode_q),
    .host_master (host_master),
    .act_req     (act_req),
    .act_prio    (act_prio),
    .gate_s      (sync_q[0]),
    .peer_hp_s   (sync_q[1]),
    .out_d       (out_d),
    .oe_d        (oe_d),
    .allowed_d   (allowed_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_out       <= '0;
      pin_oe        <= '0;
      radio_allowed <= 1'b0;
    end else begin
      pin_out       <= out_d;
      pin_oe        <= oe_d;
      radio_allowed <= allowed_d;
    end
  end

endmodule

// File: rtl/coex_arbiter_chk.sv
module coex_arbiter_chk
  import coex_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 coex_en,
  input logic                 act_req,
  input coex_mode_e           mode_q,
  input logic [1:0]           sync_q,
  input logic [COEX_PINS-1:0] pin_out,
  input logic [COEX_PINS-1:0] pin_oe,
  input logic                 radio_allowed
);

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (pin_oe == '0 && pin_out == '0 && !radio_allowed));

  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_is_legal(mode_q));

  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !coex_en |=> (pin_oe == '0 && pin_out == '0));

  a_r4_arb_pinmap: assert property (@(posedge clk) disable iff (!rst_n)
    (coex_en && mode_q == MODE_ARB) |=> pin_oe == 4'b0110);

  a_r5_needs_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    (coex_en && mode_q == MODE_ARB && !sync_q[0]) |=> !radio_allowed);

  a_r6_lan_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (coex_en && mode_q == MODE_LAN_MST && sync_q[0]) |=> !radio_allowed);

  a_r7_local_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (coex_en && mode_q == MODE_LOCAL_MST) |=> radio_allowed == $past(act_req));

  a_r9_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
    (coex_en && mode_q == MODE_ALTERNATE && !sync_q[0]) |=> !radio_allowed);

  a_r3_no_grant_unrequested: assert property (@(posedge clk) disable iff (!rst_n)
    !act_req |=> !radio_allowed);

endmodule

bind coex_arbiter coex_arbiter_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .coex_en       (coex_en),
  .act_req       (act_req),
  .mode_q        (mode_q),
  .sync_q        (sync_q),
  .pin_out       (pin_out),
  .pin_oe        (pin_oe),
  .radio_allowed (radio_allowed)
);

// File: tb/coex_arbiter_bench.sv
module coex_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       coex_en, cfg_we, host_master, act_req, act_prio;
  logic [2:0] cfg_mode;
  logic [3:0] pin_in, pin_out, pin_oe;
  logic       radio_allowed;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    string      tag;
    logic       allowed;
    logic [3:0] outv;
    logic [3:0] oev;
  } exp_t;

  exp_t exp_q[$];

  always #4 clk = ~clk;

  coex_arbiter u_coex_arbiter (
    .clk (clk), .rst_n (rst_n), .coex_en (coex_en), .cfg_we (cfg_we),
    .cfg_mode (cfg_mode), .host_master (host_master), .act_req (act_req),
    .act_prio (act_prio), .pin_in (pin_in), .pin_out (pin_out),
    .pin_oe (pin_oe), .radio_allowed (radio_allowed)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic a,
                            input logic [3:0] o, input logic [3:0] e);
    exp_t it;
    it.tag = tag; it.allowed = a; it.outv = o; it.oev = e;
    exp_q.push_back(it);
  endtask

  task automatic write_mode(input logic [2:0] code);
    cfg_mode = code;
    cfg_we   = 1'b1;
    step(1);
    cfg_we   = 1'b0;
  endtask

  // Monitor: compares queued expectations just after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if (radio_allowed !== it.allowed || pin_out !== it.outv || pin_oe !== it.oev) begin
          errors++;
          $display("FAIL %s: allowed=%b out=%b oe=%b expected allowed=%b out=%b oe=%b",
                   it.tag, radio_allowed, pin_out, pin_oe, it.allowed, it.outv, it.oev);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; coex_en = 1'b0; cfg_we = 1'b0; cfg_mode = 3'd0;
    host_master = 1'b0; act_req = 1'b0; act_prio = 1'b0; pin_in = 4'b0000;
    step(3);
    expect_out("R1 in reset", 1'b0, 4'b0000, 4'b0000);
    rst_n = 1'b1;
    step(2);
    expect_out("R1 after reset", 1'b0, 4'b0000, 4'b0000);

    coex_en = 1'b1;
    step(2);
    expect_out("R1 default scheme 0", 1'b0, 4'b0000, 4'b0110);

    // Scheme 0: request, priority, confirm handshake
    act_req = 1'b1;
    step(1);
    expect_out("R4 request low prio", 1'b0, 4'b0010, 4'b0110);
    act_prio = 1'b1;
    step(1);
    expect_out("R4 request high prio", 1'b0, 4'b0110, 4'b0110);
    pin_in = 4'b0001;
    step(2);
    expect_out("R10 confirm not yet seen", 1'b0, 4'b0110, 4'b0110);
    step(1);
    expect_out("R5 confirm grants", 1'b1, 4'b0110, 4'b0110);
    pin_in = 4'b0000;
    step(2);
    expect_out("R10 confirm drop not yet seen", 1'b1, 4'b0110, 4'b0110);
    step(1);
    expect_out("R5 confirm drop revokes", 1'b0, 4'b0110, 4'b0110);
    pin_in = 4'b1001; act_prio = 1'b0;
    step(3);
    expect_out("R5 peer priority wins", 1'b0, 4'b0010, 4'b0110);
    act_prio = 1'b1;
    step(1);
    expect_out("R5 local priority wins", 1'b1, 4'b0110, 4'b0110);
    pin_in = 4'b0000;

    // Illegal code is ignored
    write_mode(3'd5);
    step(2);
    expect_out("R2 illegal code ignored", 1'b0, 4'b0110, 4'b0110);

    // Scheme 1: LAN master
    act_prio = 1'b0;
    write_mode(3'd1);
    step(2);
    expect_out("R6 free medium", 1'b1, 4'b0000, 4'b0000);
    pin_in = 4'b0001;
    step(3);
    expect_out("R6 LAN blocks", 1'b0, 4'b0000, 4'b0000);

    // Scheme 2: local master
    write_mode(3'd2);
    step(2);
    expect_out("R7 local master busy", 1'b1, 4'b0010, 4'b0010);
    act_req = 1'b0;
    step(1);
    expect_out("R7 local idle", 1'b0, 4'b0000, 4'b0010);
    act_req = 1'b1;

    // Scheme 3: two-wire
    host_master = 1'b1;
    write_mode(3'd3);
    step(2);
    expect_out("R8 host picks local", 1'b1, 4'b0010, 4'b0010);
    host_master = 1'b0;
    step(1);
    expect_out("R8 host picks LAN blocked", 1'b0, 4'b0000, 4'b0010);
    pin_in = 4'b0000;
    step(3);
    expect_out("R8 host picks LAN free", 1'b1, 4'b0000, 4'b0010);

    // Scheme 4: alternation window
    write_mode(3'd4);
    step(2);
    expect_out("R9 outside window", 1'b0, 4'b0000, 4'b0000);
    pin_in = 4'b0001;
    step(3);
    expect_out("R9 inside window", 1'b1, 4'b0000, 4'b0000);

    // Interface disabled
    coex_en = 1'b0; pin_in = 4'b0000;
    step(1);
    expect_out("R3 disabled passes request", 1'b1, 4'b0000, 4'b0000);
    act_req = 1'b0;
    step(1);
    expect_out("R3 disabled no request", 1'b0, 4'b0000, 4'b0000);

    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule